// File: doc/BRIEF.md
# Serial Shift-Chain Port Expander

This block drives an external daisy chain of parallel-in and serial-out shift registers. Through it, a small controller gets up to eight 8-bit output ports and eight 8-bit input ports while using only four wires. It produces a shift clock by dividing the bus clock, a load/shift strobe and a serial data line. It also samples a serial return line. Software works through a byte-wide register window. That window holds the output bytes, the captured input bytes, a register with the two port counts, a clock/polarity register and a control register.

A scan is called a frame. A frame opens with a load strobe, so that the external chain latches its parallel inputs. Then the shift clock runs one bit period per chain position. The frame closes with a second strobe, which moves the shifted data to the external outputs. Captured input data reaches software only when the whole frame is done. At that point the block emits a one-cycle frame-done pulse for downstream event logic. A frame is started in one of two ways: each time software enables the block, or over and over with no software action.

Top module: `sgpio_chain_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, and shiftClk, loadStrobe and frameDone are all 0.
- R2: Register map. Bytes 0x00–0x07 are output banks 0–7 and read back what was written. Bytes 0x08–0x0F are input banks 0–7; bus writes to them have no effect. 0x2B holds the output-port count in [7:4] and the input-port count in [3:0], and reads back exactly what was written. 0x2A holds the clock select in [3:0], the shift-clock polarity in [4] and the strobe polarity in [5]. 0x28 holds the enable in [7] and the scan mode in [2:1]; unused bits read 0.
- R3: The clock select code sets the bit-period divisor D in bus cycles: 0xE→2, 0xD→3, 0xC→4, 0x7→8, 0x6→16, 0x5→32, 0x0→1024. Any other code gives 1024.
- R4: A frame lasts D×(2+T) bus cycles, where T = 8×max(output ports, input ports). The first strobe cycle is the second cycle after the enabling write. frameDone is high for exactly one cycle, immediately after the frame's last cycle.
- R5: The strobe is active for D cycles at the start of a frame and for D cycles at its end. It is active-high with idle low when bit 5 is 0, and inverted when bit 5 is 1.
- R6: The shift clock makes exactly T pulses per frame. Each bit period is D cycles: logically low for floor(D/2) cycles, then high. Bit 4 = 1 inverts the whole waveform, idle level included. The shift clock sits at its idle level while the strobe is active.
- R7: serOut sends bit 7 of the highest output bank first, down to bit 0 of bank 0, for (output ports × 8) bits. It then sends zeros for the rest of the T bits. Each bit is held for its whole bit period.
- R8: serIn is sampled in the last cycle of each bit period. The k-th sample (k from 0) becomes input bit (input ports × 8 − 1 − k). Samples beyond the input bit count are dropped. Input banks at or above the input-port count read 0 after a frame.
- R9: Input bytes change only on the edge that raises frameDone, and are readable while frameDone is high. A partial frame is never visible.
- R10: With bit 2 of 0x28 clear, each write of 0x28 that has bit 7 set runs exactly one frame.
- R11: With bit 2 of 0x28 set and enable on, frames repeat back to back. Successive frameDone pulses are D×(2+T)+1 cycles apart.
- R12: Clearing the enable during a frame lets that frame complete, with its frameDone pulse. No further frame starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 6 | Register byte address for reads and writes |
| regWrEn | input | 1 | Write strobe for the addressed byte |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data of the addressed byte |
| serIn | input | 1 | Serial data returning from the chain |
| serOut | output | 1 | Serial data into the chain |
| shiftClk | output | 1 | Chain shift clock |
| loadStrobe | output | 1 | Chain load/update strobe |
| frameDone | output | 1 | One-cycle pulse at the end of each frame |

## Verification
Every timed result has a fixed distance from the write that enables the block. The first strobe cycle comes two cycles after that write. frameDone comes D×(2+T)+1 cycles after it, and the input bytes are already updated in the same cycle that frameDone is high. The bench counts falling clock edges from the enabling write and compares the count with that formula for each divisor. It reads the input bytes at the falling edge where frameDone is first seen high. A chain model on falling edges follows the logical shift-clock transitions, collects the serial output and sets the next serial input bit only after the sampling edge. In periodic mode, the bench measures the distance between successive frameDone pulses against D×(2+T)+1.

// File: rtl/sgpio_chain_pkg.sv
package sgpio_chain_pkg;

  localparam int DIV_W = 11;

  typedef struct packed {
    logic frameStart;
    logic shiftStep;
    logic sampleIn;
    logic commit;
  } chain_stb_t;

  typedef struct packed {
    logic       enable;
    logic       periodic;
    logic       kick;
    logic [3:0] clkSel;
    logic       sclkPol;
    logic       loadPol;
    logic [3:0] outPorts;
    logic [3:0] inPorts;
  } chain_cfg_t;

  function automatic logic [DIV_W-1:0] selToDiv(input logic [3:0] sel);
    case (sel)
      4'hE:    selToDiv = DIV_W'(2);
      4'hD:    selToDiv = DIV_W'(3);
      4'hC:    selToDiv = DIV_W'(4);
      4'h7:    selToDiv = DIV_W'(8);
      4'h6:    selToDiv = DIV_W'(16);
      4'h5:    selToDiv = DIV_W'(32);
      default: selToDiv = DIV_W'(1024);
    endcase
  endfunction

  function automatic int unsigned clampPorts(input logic [3:0] cnt, input int unsigned maxPorts);
    clampPorts = (int'(cnt) > maxPorts) ? maxPorts : int'(cnt);
  endfunction

endpackage

// File: rtl/sgpio_chain_dp.sv
module sgpio_chain_dp
  import sgpio_chain_pkg::*;
#(
  parameter int PORTS  = 8,
  parameter int PORT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  chain_stb_t stb,
  input  logic       serIn,
  output logic       serOut,
  output chain_cfg_t cfg
);
  localparam int TOTAL = PORTS * PORT_W;
  localparam logic [5:0] IN_BASE   = 6'h08;
  localparam logic [5:0] CTRL_ADDR = 6'h28;
  localparam logic [5:0] CFG_ADDR  = 6'h2A;
  localparam logic [5:0] PORT_ADDR = 6'h2B;

  logic [PORT_W-1:0] outReg [PORTS];
  logic [TOTAL-1:0]  outFlat, inReg, outShift, inShift;
  logic              ctrlEn;
  logic [1:0]        ctrlMode;
  logic [5:0]        cfgReg;
  logic [7:0]        portReg;
  int unsigned       outBits;

  for (genvar b = 0; b < PORTS; b++) begin : g_flat
    assign outFlat[b*PORT_W +: PORT_W] = outReg[b];
  end

  assign outBits = clampPorts(portReg[7:4], PORTS) * PORT_W;
  assign serOut  = outShift[TOTAL-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < PORTS; b++) outReg[b] <= '0;
      ctrlEn   <= 1'b0;
      ctrlMode <= 2'b00;
      cfgReg   <= '0;
      portReg  <= '0;
      inReg    <= '0;
      outShift <= '0;
      inShift  <= '0;
    end else begin
      if (regWrEn) begin
        for (int b = 0; b < PORTS; b++)
          if (regAddr == 6'(b)) outReg[b] <= regWrData[PORT_W-1:0];
        if (regAddr == CTRL_ADDR) begin
          ctrlEn   <= regWrData[7];
          ctrlMode <= regWrData[2:1];
        end
        if (regAddr == CFG_ADDR)  cfgReg  <= regWrData[5:0];
        if (regAddr == PORT_ADDR) portReg <= regWrData;
      end
      if (stb.frameStart) begin
        outShift <= outFlat << (TOTAL - outBits);
        inShift  <= '0;
      end else begin
        if (stb.shiftStep) outShift <= outShift << 1;
        if (stb.sampleIn)  inShift  <= {inShift[TOTAL-2:0], serIn};
      end
      if (stb.commit) inReg <= inShift;
    end
  end

  always_comb begin
    regRdData = 8'h00;
    for (int b = 0; b < PORTS; b++) begin
      if (regAddr == 6'(b))           regRdData = 8'(outReg[b]);
      if (regAddr == IN_BASE + 6'(b)) regRdData = 8'(inReg[b*PORT_W +: PORT_W]);
    end
    if (regAddr == CTRL_ADDR) regRdData = {ctrlEn, 4'b0000, ctrlMode, 1'b0};
    if (regAddr == CFG_ADDR)  regRdData = {2'b00, cfgReg};
    if (regAddr == PORT_ADDR) regRdData = portReg;
  end

  always_comb begin
    cfg.enable   = ctrlEn;
    cfg.periodic = ctrlMode[1];
    cfg.kick     = regWrEn && (regAddr == CTRL_ADDR) && regWrData[7];
    cfg.clkSel   = cfgReg[3:0];
    cfg.sclkPol  = cfgReg[4];
    cfg.loadPol  = cfgReg[5];
    cfg.outPorts = portReg[7:4];
    cfg.inPorts  = portReg[3:0];
  end
endmodule

// File: rtl/sgpio_chain_ctl.sv
module sgpio_chain_ctl
  import sgpio_chain_pkg::*;
#(
  parameter int PORTS  = 8,
  parameter int PORT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  chain_cfg_t cfg,
  output chain_stb_t stb,
  output logic       shiftClk,
  output logic       loadStrobe,
  output logic       frameDone
);
  localparam int TOTAL = PORTS * PORT_W;
  localparam int BIT_W = $clog2(TOTAL + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_UPDATE} st_t;

  st_t             st;
  logic [DIV_W-1:0] phCnt, divQ;
  logic [BIT_W-1:0] bitCnt, inBitsQ, totalQ, inBitsNow, outBitsNow, totalNow;
  logic            pending, phLast, frameDoneQ;

  assign inBitsNow  = BIT_W'(clampPorts(cfg.inPorts, PORTS) * PORT_W);
  assign outBitsNow = BIT_W'(clampPorts(cfg.outPorts, PORTS) * PORT_W);
  assign totalNow   = (inBitsNow > outBitsNow) ? inBitsNow : outBitsNow;
  assign phLast     = (phCnt == divQ - 1'b1);

  always_comb begin
    stb.frameStart = (st == ST_IDLE) && cfg.enable && (cfg.periodic || pending);
    stb.shiftStep  = (st == ST_SHIFT) && phLast;
    stb.sampleIn   = stb.shiftStep && (bitCnt < inBitsQ);
    stb.commit     = (st == ST_UPDATE) && phLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      phCnt      <= '0;
      bitCnt     <= '0;
      divQ       <= DIV_W'(1024);
      inBitsQ    <= '0;
      totalQ     <= '0;
      pending    <= 1'b0;
      frameDoneQ <= 1'b0;
    end else begin
      frameDoneQ <= stb.commit;
      if (cfg.kick)                pending <= 1'b1;
      else if (!cfg.enable)        pending <= 1'b0;
      else if (stb.frameStart)     pending <= 1'b0;
      case (st)
        ST_IDLE: if (stb.frameStart) begin
          st      <= ST_LOAD;
          phCnt   <= '0;
          divQ    <= selToDiv(cfg.clkSel);
          inBitsQ <= inBitsNow;
          totalQ  <= totalNow;
        end
        ST_LOAD: if (phLast) begin
          phCnt  <= '0;
          bitCnt <= '0;
          st     <= (totalQ == '0) ? ST_UPDATE : ST_SHIFT;
        end else phCnt <= phCnt + 1'b1;
        ST_SHIFT: if (phLast) begin
          phCnt <= '0;
          if (bitCnt == totalQ - 1'b1) st <= ST_UPDATE;
          else bitCnt <= bitCnt + 1'b1;
        end else phCnt <= phCnt + 1'b1;
        default: if (phLast) begin
          phCnt <= '0;
          st    <= ST_IDLE;
        end else phCnt <= phCnt + 1'b1;
      endcase
    end
  end

  assign shiftClk   = ((st == ST_SHIFT) && (phCnt >= (divQ >> 1))) ^ cfg.sclkPol;
  assign loadStrobe = ((st == ST_LOAD) || (st == ST_UPDATE)) ^ cfg.loadPol;
  assign frameDone  = frameDoneQ;
endmodule

// File: rtl/sgpio_chain_ctrl.sv
module sgpio_chain_ctrl
  import sgpio_chain_pkg::*;
#(
  parameter int PORTS  = 8,
  parameter int PORT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       serIn,
  output logic       serOut,
  output logic       shiftClk,
  output logic       loadStrobe,
  output logic       frameDone
);
  chain_cfg_t cfg;
  chain_stb_t stb;

  sgpio_chain_dp #(.PORTS(PORTS), .PORT_W(PORT_W)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .stb(stb),
    .serIn(serIn), .serOut(serOut), .cfg(cfg)
  );

  sgpio_chain_ctl #(.PORTS(PORTS), .PORT_W(PORT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb),
    .shiftClk(shiftClk), .loadStrobe(loadStrobe), .frameDone(frameDone)
  );
endmodule

// File: rtl/sgpio_chain_chk.sv
module sgpio_chain_chk (
  input logic       clk,
  input logic       rstN,
  input logic [5:0] regAddr,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic [7:0] regRdData,
  input logic       shiftClk,
  input logic       loadStrobe,
  input logic       frameDone,
  input logic       sclkPol,
  input logic       loadPol
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone); // R4

  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> ($past(loadStrobe) != $past(loadPol))); // R5

  AST_CLK_QUIET_IN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe != loadPol) |-> (shiftClk == sclkPol)); // R6

  AST_PORTS_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 6'h2B) |=> (regAddr != 6'h2B) || (regRdData == $past(regWrData))); // R2

  AST_INDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!frameDone && regAddr[5:3] == 3'b001 && regAddr == $past(regAddr)) |-> $stable(regRdData)); // R9
endmodule

bind sgpio_chain_ctrl sgpio_chain_chk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .shiftClk(shiftClk),
  .loadStrobe(loadStrobe), .frameDone(frameDone),
  .sclkPol(cfg.sclkPol), .loadPol(cfg.loadPol)
);

// File: tb/tb_sgpio_chain_ctrl.sv
`timescale 1ns/10ps
module tb_sgpio_chain_ctrl;
  logic clk = 1'b0, rstN = 1'b0;
  logic [5:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0, regRdData;
  logic serIn = 1'b0;
  logic serOut, shiftClk, loadStrobe, frameDone;

  sgpio_chain_ctrl dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .serIn(serIn),
    .serOut(serOut), .shiftClk(shiftClk), .loadStrobe(loadStrobe),
    .frameDone(frameDone)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [3:0]  sel;
    logic [1:0]  pol;
    logic [3:0]  outP;
    logic [3:0]  inP;
    logic [63:0] outData;
    logic [63:0] inPat;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{sel:4'hE, pol:2'b00, outP:4'd2, inP:4'd3, outData:64'h0000_0000_0000_A5C3, inPat:64'h0123_4567_89AB_CDEF},
    '{sel:4'hD, pol:2'b11, outP:4'd8, inP:4'd1, outData:64'hF00D_1234_8001_7E5A, inPat:64'hFFFF_0000_FFFF_00B6},
    '{sel:4'hC, pol:2'b01, outP:4'd0, inP:4'd8, outData:64'hDEAD_BEEF_CAFE_F00D, inPat:64'h8421_1248_F0E1_D2C3},
    '{sel:4'h7, pol:2'b10, outP:4'd4, inP:4'd0, outData:64'h0000_0000_9C3E_71A8, inPat:64'hAAAA_AAAA_AAAA_AAAA},
    '{sel:4'h6, pol:2'b00, outP:4'd1, inP:4'd1, outData:64'h0000_0000_0000_0081, inPat:64'h0000_0000_0000_0035},
    '{sel:4'h5, pol:2'b01, outP:4'd1, inP:4'd2, outData:64'h0000_0000_0000_005C, inPat:64'h0000_0000_0000_C3A7},
    '{sel:4'h3, pol:2'b00, outP:4'd0, inP:4'd0, outData:64'h0000_0000_0000_0000, inPat:64'h0000_0000_0000_0000}
  };

  int checks = 0, fails = 0, cycles = 0;
  logic finished = 1'b0;

  // chain model state
  logic benchSclkPol = 1'b0, benchLoadPol = 1'b0, prevLg = 1'b0;
  logic [63:0] capOut = '0, curPat = '0;
  int rises = 0, idx = 0, loadCnt = 0, hiCnt = 0;

  always @(negedge clk) begin
    logic lg;
    lg = shiftClk ^ benchSclkPol;
    if (loadStrobe ^ benchLoadPol) loadCnt++;
    if (lg) hiCnt++;
    if (lg && !prevLg) begin capOut = {capOut[62:0], serOut}; rises++; end
    if (!lg && prevLg) begin idx++; serIn = (idx < 64) ? curPat[idx] : 1'b0; end
    prevLg = lg;
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    regAddr = a;
    #0.25;
    d = regRdData;
  endtask

  task automatic waitDone(input int limit, output int n);
    n = 0;
    while (!frameDone && n < limit) begin @(negedge clk); n++; end
  endtask

  function automatic int expDiv(input logic [3:0] s);
    case (s)
      4'hE: return 2;   4'hD: return 3;  4'hC: return 4;
      4'h7: return 8;   4'h6: return 16; 4'h5: return 32;
      default: return 1024;
    endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog R4 actual=%0d expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic [63:0] expOut, expIn, gotIn;
    int n, d, t, ob, ib;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(shiftClk == 1'b0 && loadStrobe == 1'b0 && frameDone == 1'b0, "R1 pins",
        {shiftClk, loadStrobe, frameDone}, 0);
    for (int a = 0; a < 16; a++) begin rd(6'(a), rv); chk(rv == 8'h00, "R1 data reg", rv, 0); end
    rd(6'h28, rv); chk(rv == 8'h00, "R1 ctrl", rv, 0);
    rd(6'h2A, rv); chk(rv == 8'h00, "R1 cfg", rv, 0);
    rd(6'h2B, rv); chk(rv == 8'h00, "R1 ports", rv, 0);

    // R2: register map
    wr(6'h03, 8'h5A); rd(6'h03, rv); chk(rv == 8'h5A, "R2 out readback", rv, 8'h5A);
    wr(6'h0B, 8'hFF); rd(6'h0B, rv); chk(rv == 8'h00, "R2 in write ignored", rv, 0);
    wr(6'h2B, 8'hC5); rd(6'h2B, rv); chk(rv == 8'hC5, "R2 ports readback", rv, 8'hC5);
    wr(6'h2A, 8'hFF); rd(6'h2A, rv); chk(rv == 8'h3F, "R2 cfg readback", rv, 8'h3F);
    wr(6'h28, 8'h7E); rd(6'h28, rv); chk(rv == 8'h06, "R2 ctrl readback", rv, 8'h06);
    wr(6'h28, 8'h00);

    // table of frames: R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      d  = expDiv(VECS[v].sel);
      ob = int'(VECS[v].outP) * 8;
      ib = int'(VECS[v].inP) * 8;
      t  = (ob > ib) ? ob : ib;
      expOut = '0;
      for (int k = 0; k < t; k++)
        expOut[t-1-k] = (k < ob) ? VECS[v].outData[ob-1-k] : 1'b0;
      expIn = '0;
      for (int k = 0; k < ib; k++) expIn[ib-1-k] = VECS[v].inPat[k];

      wr(6'h28, 8'h00);
      wr(6'h2A, {2'b00, VECS[v].pol, VECS[v].sel});
      wr(6'h2B, {VECS[v].outP, VECS[v].inP});
      for (int b = 0; b < 8; b++) wr(6'(b), VECS[v].outData[b*8 +: 8]);
      @(negedge clk);
      benchSclkPol = VECS[v].pol[0]; benchLoadPol = VECS[v].pol[1];
      curPat = VECS[v].inPat; serIn = VECS[v].inPat[0];
      capOut = '0; rises = 0; idx = 0; loadCnt = 0; hiCnt = 0; prevLg = 1'b0;
      chk(shiftClk == VECS[v].pol[0], "R6 idle clock level", shiftClk, VECS[v].pol[0]);
      chk(loadStrobe == VECS[v].pol[1], "R5 idle strobe level", loadStrobe, VECS[v].pol[1]);
      wr(6'h28, 8'h80);
      waitDone(5000, n);
      chk(n == d*(2+t)+1, "R3 R4 frame length", n, d*(2+t)+1);
      gotIn = '0;
      for (int b = 0; b < 8; b++) begin rd(6'(8+b), rv); gotIn[b*8 +: 8] = rv; end
      chk(gotIn == expIn, "R8 R9 input bytes", gotIn, expIn);
      chk(capOut == expOut, "R7 serial output", capOut, expOut);
      chk(rises == t, "R6 clock pulses", rises, t);
      chk(hiCnt == t*(d - d/2), "R6 clock high time", hiCnt, t*(d - d/2));
      chk(loadCnt == 2*d, "R5 strobe cycles", loadCnt, 2*d);
      @(negedge clk);
      chk(frameDone == 1'b0, "R4 done one cycle", frameDone, 0);
    end

    // R10: one-shot mode runs no second frame
    n = 0;
    for (int c = 0; c < 300; c++) begin @(negedge clk); if (frameDone) n++; end
    chk(n == 0, "R10 single frame only", n, 0);

    // R11: periodic rescans, D=2, one port each, T=8
    wr(6'h28, 8'h00);
    wr(6'h2A, 8'h0E);
    wr(6'h2B, 8'h11);
    @(negedge clk);
    benchSclkPol = 1'b0; benchLoadPol = 1'b0;
    wr(6'h28, 8'h84);
    waitDone(200, n);
    chk(n == 21, "R11 first frame", n, 21);
    @(negedge clk); waitDone(200, n);
    chk(n == 20, "R11 spacing a", n + 1, 21);
    @(negedge clk); waitDone(200, n);
    chk(n == 20, "R11 spacing b", n + 1, 21);

    // R12: disable mid-frame lets it finish then stops
    repeat (5) @(negedge clk);
    wr(6'h28, 8'h04);
    waitDone(200, n);
    chk(frameDone == 1'b1, "R12 current frame completes", frameDone, 1);
    n = 0;
    for (int c = 0; c < 300; c++) begin @(negedge clk); if (frameDone) n++; end
    chk(n == 0, "R12 no new frame", n, 0);
    chk(loadStrobe == 1'b0 && shiftClk == 1'b0, "R12 idle pins", {loadStrobe, shiftClk}, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule